// File: doc/BRIEF.md
# Output Voltage Supervisor with Over-Voltage Latch

This block watches a digital reading of a regulator's output voltage and compares it with a programmed target code. Each comparison point is a fixed-point fraction of the target. The block raises a power-good flag only after soft-start has completed and the output sits inside its window.

A low output is reported with hysteresis. The flag trips at one fraction of the target and clears at a higher one. This condition only withdraws power-good and is never latched.

A high output is treated as a fault. The block latches it, takes over the PWM stage and drops power-good. While the latch is set, the PWM stage is pulled low whenever the output is above the limit. It is released to high impedance once the output has fallen a hysteresis band below that limit. Over a persisting fault this makes the clamp cycle as a shunt regulator. Only a power-on reset clears the latch.

Top module: `vout_supervisor`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `pgood`, `ov_latched`, `force_low` and `force_tristate` are all 0.
- R2: If meas*512 < target*461 at a clock edge, the under-voltage state is set and `pgood` reads 0 after that edge.
- R3: Once set, the under-voltage state clears only at an edge where meas*512 > target*471. Readings between the two thresholds leave it unchanged.
- R4: Under-voltage never sets `ov_latched`, `force_low` or `force_tristate`.
- R5: At an edge where target != 0 and meas*512 > target*589, `ov_latched` and `force_low` both become 1 after that edge.
- R6: Once `ov_latched` is 1, it stays 1 whatever `target`, `meas` or `ss_done` do, until `por_n` goes low.
- R7: While latched, the clamp state behaves as follows. It goes to force-low when meas*512 > target*589. It goes to tri-state (`force_tristate`=1, `force_low`=0) when meas*512 < target*579. Otherwise it holds. The two force outputs are never 1 together.
- R8: `pgood` equals the registered values of the following, taken from the previous edge: `ss_done` is 1, target != 0, no under-voltage, and no over-voltage latch.
- R9: A target of 0 never sets the over-voltage latch, and it holds `pgood` at 0 after the edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| target | input | VW | Programmed target voltage code; 0 means off |
| meas | input | VW | Measured output voltage in the same units |
| ss_done | input | 1 | Soft-start sequence finished |
| pgood | output | 1 | Output in window and soft-start complete |
| ov_latched | output | 1 | Over-voltage fault latched |
| force_low | output | 1 | Command PWM stage to drive low |
| force_tristate | output | 1 | Command PWM stage to high impedance |

## Verification
The assertions take the target and measurement codes to be sampled synchronously with the clock, with one reading per edge. They also assume that a latched fault is cleared only through `por_n`. The stimulus therefore changes inputs only on the falling clock edge. Random measurements are generated as fractions of the target between roughly 0.74 and 1.37, so that every threshold is crossed in both directions. The target is kept small enough that the measurement code never overflows. Occasional zero targets and reset pulses are mixed into the random sequence.

// File: rtl/vsup_pkg.sv
package vsup_pkg;
   typedef enum logic [1:0] {
      CLAMP_OFF = 2'd0,
      CLAMP_LOW = 2'd1,
      CLAMP_TRI = 2'd2
   } clamp_e;

   localparam int unsigned FRAC_DEF      = 9;
   localparam int unsigned UV_FALL_DEF   = 461;
   localparam int unsigned UV_RISE_DEF   = 471;
   localparam int unsigned OV_TRIP_DEF   = 589;
   localparam int unsigned OV_REL_DEF    = 579;
endpackage

// File: rtl/vsup_scale_cmp.sv
module vsup_scale_cmp #(
   parameter int unsigned VW    = 12,
   parameter int unsigned FRAC  = 9,
   parameter int unsigned NUM   = 512,
   parameter bit          BELOW = 1'b0
) (
   input  logic [VW-1:0] target,
   input  logic [VW-1:0] meas,
   output logic          hit
);
   localparam int unsigned PW = VW + FRAC + 1;

   if (NUM >= (2 ** (FRAC + 1))) begin : g_bad_num
      $error("vsup_scale_cmp: NUM exceeds two times unity");
   end

   logic [PW-1:0] meas_s;
   logic [PW-1:0] thr_s;

   always_comb begin
      meas_s = {{(PW-VW-FRAC){1'b0}}, meas, {FRAC{1'b0}}};
      thr_s  = PW'(target) * PW'(NUM);
   end

   if (BELOW) begin : g_below
      assign hit = meas_s < thr_s;
   end else begin : g_above
      assign hit = meas_s > thr_s;
   end
endmodule

// File: rtl/vsup_uv_hyst.sv
module vsup_uv_hyst (
   input  logic clk,
   input  logic por_n,
   input  logic below_fall,
   input  logic above_rise,
   output logic uv
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          uv <= 1'b1;
      else if (uv)         uv <= !above_rise;
      else                 uv <= below_fall;
   end

   // R3: between thresholds an active flag holds
   a_r3_uv_hold: assert property (@(posedge clk) disable iff (!por_n)
      (uv && !above_rise) |=> uv);
   // R2: falling below the lower threshold sets the flag
   a_r2_uv_set: assert property (@(posedge clk) disable iff (!por_n)
      (below_fall) |=> uv);
endmodule

// File: rtl/vsup_ov_clamp.sv
module vsup_ov_clamp
   import vsup_pkg::*;
(
   input  logic   clk,
   input  logic   por_n,
   input  logic   tgt_nz,
   input  logic   above_trip,
   input  logic   below_rel,
   output clamp_e state
);
   clamp_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         CLAMP_OFF: if (tgt_nz && above_trip) nxt = CLAMP_LOW;
         CLAMP_LOW: if (!above_trip && below_rel) nxt = CLAMP_TRI;
         CLAMP_TRI: if (above_trip) nxt = CLAMP_LOW;
         default:   nxt = CLAMP_LOW;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) state <= CLAMP_OFF;
      else        state <= nxt;
   end

   // R6: latch is sticky
   a_r6_latch_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (state != CLAMP_OFF) |=> (state != CLAMP_OFF));
   // R5: a trip above the limit clamps low on the next cycle
   a_r5_trip_clamps: assert property (@(posedge clk) disable iff (!por_n)
      (tgt_nz && above_trip) |=> (state == CLAMP_LOW));
   // R9: zero target cannot start a fault
   a_r9_no_trip_off: assert property (@(posedge clk) disable iff (!por_n)
      (state == CLAMP_OFF && !tgt_nz) |=> (state == CLAMP_OFF));
endmodule

// File: rtl/vout_supervisor.sv
module vout_supervisor
   import vsup_pkg::*;
#(
   parameter int unsigned VW      = 12,
   parameter int unsigned FRAC    = FRAC_DEF,
   parameter int unsigned UV_FALL = UV_FALL_DEF,
   parameter int unsigned UV_RISE = UV_RISE_DEF,
   parameter int unsigned OV_TRIP = OV_TRIP_DEF,
   parameter int unsigned OV_REL  = OV_REL_DEF
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic [VW-1:0] target,
   input  logic [VW-1:0] meas,
   input  logic          ss_done,
   output logic          pgood,
   output logic          ov_latched,
   output logic          force_low,
   output logic          force_tristate
);
   if (VW < 2) begin : g_bad_vw
      $error("vout_supervisor: VW too small");
   end
   if (!(UV_FALL < UV_RISE && UV_RISE < OV_REL && OV_REL < OV_TRIP)) begin : g_bad_thr
      $error("vout_supervisor: thresholds out of order");
   end

   logic   below_fall, above_rise, above_trip, below_rel;
   logic   uv, tgt_nz, ss_q, tnz_q;
   clamp_e cst;

   assign tgt_nz = |target;

   vsup_scale_cmp #(.VW(VW), .FRAC(FRAC), .NUM(UV_FALL), .BELOW(1'b1)) u_cmp_fall (
      .target(target), .meas(meas), .hit(below_fall));
   vsup_scale_cmp #(.VW(VW), .FRAC(FRAC), .NUM(UV_RISE), .BELOW(1'b0)) u_cmp_rise (
      .target(target), .meas(meas), .hit(above_rise));
   vsup_scale_cmp #(.VW(VW), .FRAC(FRAC), .NUM(OV_TRIP), .BELOW(1'b0)) u_cmp_trip (
      .target(target), .meas(meas), .hit(above_trip));
   vsup_scale_cmp #(.VW(VW), .FRAC(FRAC), .NUM(OV_REL), .BELOW(1'b1)) u_cmp_rel (
      .target(target), .meas(meas), .hit(below_rel));

   vsup_uv_hyst u_uv (
      .clk(clk), .por_n(por_n), .below_fall(below_fall),
      .above_rise(above_rise), .uv(uv));

   vsup_ov_clamp u_ov (
      .clk(clk), .por_n(por_n), .tgt_nz(tgt_nz), .above_trip(above_trip),
      .below_rel(below_rel), .state(cst));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ss_q  <= 1'b0;
         tnz_q <= 1'b0;
      end else begin
         ss_q  <= ss_done;
         tnz_q <= tgt_nz;
      end
   end

   assign ov_latched     = (cst != CLAMP_OFF);
   assign force_low      = (cst == CLAMP_LOW);
   assign force_tristate = (cst == CLAMP_TRI);
   assign pgood          = ss_q && tnz_q && !uv && !ov_latched;

   // R7: never both force commands
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!por_n)
      !(force_low && force_tristate));
   // R4: force commands only come from the latched fault
   a_r4_force_needs_ov: assert property (@(posedge clk) disable iff (!por_n)
      (force_low || force_tristate) |-> ov_latched);
   // R8: power-good only rises after soft-start was seen
   a_r8_pgood_needs_ss: assert property (@(posedge clk) disable iff (!por_n)
      $rose(pgood) |-> $past(ss_done));
   // R9: zero target drops power-good
   a_r9_zero_target: assert property (@(posedge clk) disable iff (!por_n)
      (target == '0) |=> !pgood);
endmodule

// File: tb/vout_supervisor_tb.sv
module vout_supervisor_tb;
   localparam int VW = 12;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic [VW-1:0] target = '0;
   logic [VW-1:0] meas = '0;
   logic          ss_done = 1'b0;
   logic          pgood, ov_latched, force_low, force_tristate;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   bit m_uv, m_ss, m_tnz;
   int m_st; // 0 off, 1 low, 2 tri

   always #5 clk = ~clk;

   vout_supervisor #(.VW(VW)) u_dut (
      .clk(clk), .por_n(por_n), .target(target), .meas(meas), .ss_done(ss_done),
      .pgood(pgood), .ov_latched(ov_latched), .force_low(force_low),
      .force_tristate(force_tristate));

   function automatic bit gt(int m, int t, int num);
      return longint'(m) * 512 > longint'(t) * num;
   endfunction
   function automatic bit lt(int m, int t, int num);
      return longint'(m) * 512 < longint'(t) * num;
   endfunction

   task automatic model_reset();
      m_uv = 1; m_ss = 0; m_tnz = 0; m_st = 0;
   endtask

   task automatic model_step(int t, int m, bit s);
      if (m_uv) m_uv = !gt(m, t, 471);
      else      m_uv = lt(m, t, 461);
      case (m_st)
         0: if (t != 0 && gt(m, t, 589)) m_st = 1;
         1: if (!gt(m, t, 589) && lt(m, t, 579)) m_st = 2;
         default: if (gt(m, t, 589)) m_st = 1;
      endcase
      m_ss = s; m_tnz = (t != 0);
   endtask

   task automatic chk1(string tag, string name, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      chk1(tag, "pgood", pgood, m_ss && m_tnz && !m_uv && m_st == 0);
      chk1(tag, "ov_latched", ov_latched, m_st != 0);
      chk1(tag, "force_low", force_low, m_st == 1);
      chk1(tag, "force_tristate", force_tristate, m_st == 2);
   endtask

   // drive at negedge, let one edge pass, check at next negedge
   task automatic step(string tag, int t, int m, bit s);
      target = VW'(t); meas = VW'(m); ss_done = s;
      @(posedge clk);
      model_step(t, m, s);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic do_reset();
      por_n = 1'b0;
      model_reset();
      @(negedge clk);
      check_all("R1");
      @(negedge clk);
      por_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (2) @(negedge clk);
      check_all("R1");
      por_n = 1'b1;
      // first cycle after reset with inputs idle
      step("R1", 0, 0, 0);

      // target 400: fall 360.2, rise 367.97, trip 460.2, release 452.3
      step("R8", 400, 400, 1);        // in window, pgood
      step("R2", 400, 360, 1);        // below fall -> uv
      step("R3", 400, 367, 1);        // between -> hold uv
      step("R3", 400, 368, 1);        // above rise -> clear
      step("R3", 400, 362, 1);        // between, uv clear -> stays clear
      step("R4", 400, 100, 1);        // deep uv, no force
      step("R8", 400, 400, 0);        // ss not done
      step("R9", 0, 500, 1);          // off target: no trip, pgood low
      step("R8", 400, 400, 1);
      step("R5", 400, 461, 1);        // trip
      step("R7", 400, 455, 1);        // hold low
      step("R7", 400, 452, 1);        // release -> tri
      step("R7", 400, 458, 1);        // hold tri
      step("R7", 400, 470, 1);        // back to low
      step("R6", 400, 400, 1);        // stays latched
      step("R6", 0, 0, 0);            // still latched
      do_reset();
      step("R1", 400, 400, 1);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         int t, m;
         if ($urandom_range(0, 199) == 0) do_reset();
         t = ($urandom_range(0, 15) == 0) ? 0 : int'($urandom_range(1, 2800));
         m = (t * int'($urandom_range(380, 700))) / 512;
         if (t == 0) m = int'($urandom_range(0, 4095));
         step("R8", t, m, $urandom_range(0, 7) != 0);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule